// File: doc/BRIEF.md
# Constant-Weight Multiply-Accumulate Tree

The block forms a weighted sum of up to eight signed input samples in one pass. Each sample is multiplied by its own signed integer weight. The weights are fixed when the design is elaborated, so the hardware holds no coefficient storage that software can write. The sum passes through an optional chain of pipeline registers. It leaves the block either at full precision or as a narrower word with a chosen number of low bits dropped.

Two arithmetic styles are available and both give the same bits. The multiplier style multiplies each sample by its weight and adds the products. The distributed-arithmetic style builds a table of every partial sum of the weights and walks the sample bits one plane at a time. An automatic setting picks the table style when the tap count and the sample width are small. A clock enable can freeze the registers, and an asynchronous clear can zero them. Each of the two controls is included or left out by parameter.

Top module: `coef_sop`

## Requirements
- R1: With full precision selected, `result` equals the exact two's-complement sum over k < N_TAPS of sample k times weight k. Sample k sits at `din[k*DATA_W +: DATA_W]`, tap 0 in the low bits. `result` is DATA_W + COEF_W + ceil(log2(N_TAPS)) bits wide.
- R2: The full-precision sum never overflows. This holds even when every sample is the most negative or the most positive code.
- R3: The distributed-arithmetic style (IMPL_DA) and the multiplier style (IMPL_MULT) produce identical `result` bits for identical inputs. IMPL_AUTO selects the table style when N_TAPS <= 4 and DATA_W <= 12, and selects multipliers otherwise.
- R4: With full precision off, `result` is the low OUT_W bits of the exact sum shifted right arithmetically by TRUNC_LSB, which rounds toward negative infinity. Upper bits are dropped without saturation.
- R5: With the enable high, a change at `din` reaches `result` exactly PIPE_STAGES rising clock edges later. Before that edge, `result` still shows the previous sum.
- R6: With PIPE_STAGES = 0, `result` follows `din` combinationally, with no clock edge needed.
- R7: When USE_ENA = 1 and `ena` is low, every pipeline register keeps its value. Once `ena` returns high, the sums already in flight come out in their original order.
- R8: When USE_ACLR = 1 and `aclr` is high, every pipeline register is zero at once, without waiting for a clock edge. The registers stay zero for as long as `aclr` is held.
- R9: When USE_ENA = 0, the level on `ena` has no effect and the registers advance on every edge.
- R10: Weight-list entries at index N_TAPS and above have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| aclr | input | 1 | Active-high asynchronous clear of all pipeline registers (used when USE_ACLR = 1) |
| ena | input | 1 | Active-high register enable (used when USE_ENA = 1) |
| din | input | N_TAPS*DATA_W | Packed signed samples, tap 0 in the least significant slice |
| result | output | RES_W | Weighted sum: full width, or OUT_W bits after dropping TRUNC_LSB low bits |

## Verification
The hardest situation to reach from the ports is a pipeline whose stages hold different sums at the moment the enable drops. A stall check on a flushed pipeline cannot tell a frozen stage from a stage that reloaded the same value. The stimulus therefore changes the samples one edge before lowering `ena`, so the two stages hold different sums, and then changes the samples again while the pipeline is stalled. After `ena` rises, the bench checks that the older in-flight sum appears first and the stalled input second. The clear is raised halfway through a clock period and `result` is sampled before the next edge, so the check separates an asynchronous clear from a synchronous one.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int MAX_TAPS      = 8;
    localparam int DA_MAX_TAPS   = 4;
    localparam int DA_MAX_DATA_W = 12;

    typedef int coef_tab_t [MAX_TAPS];

    typedef enum logic [1:0] {
        IMPL_DA   = 2'd0,
        IMPL_MULT = 2'd1,
        IMPL_AUTO = 2'd2
    } sop_impl_e;

    // Growth bits needed to add n equally wide terms.
    function automatic int growth_bits(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

    // Resolve the arithmetic style chosen at elaboration.
    function automatic bit pick_table(input sop_impl_e impl, input int n_taps, input int data_w);
        if (impl == IMPL_DA)   return 1'b1;
        if (impl == IMPL_MULT) return 1'b0;
        return (n_taps <= DA_MAX_TAPS) && (data_w <= DA_MAX_DATA_W);
    endfunction

endpackage

// File: rtl/sop_core.sv
// Exact weighted sum of N_TAPS signed samples, purely combinational.
module sop_core
    import sop_pkg::*;
#(
    parameter int        N_TAPS  = 8,
    parameter int        DATA_W  = 8,
    parameter coef_tab_t COEFS   = '{default: 0},
    parameter int        FULL_W  = 22,
    parameter bit        USE_TBL = 1'b0
) (
    input  logic [N_TAPS*DATA_W-1:0] din,
    output logic [FULL_W-1:0]        sum
);

    if (USE_TBL) begin : g_da
        localparam int LUT_N = 1 << N_TAPS;

        // Sum of the weights whose tap bit is set in addr.
        function automatic logic signed [FULL_W-1:0] lut_val(input int addr);
            logic signed [FULL_W-1:0] v;
            v = '0;
            for (int k = 0; k < N_TAPS; k++) begin
                if (addr[k]) v = v + FULL_W'(COEFS[k]);
            end
            return v;
        endfunction

        logic signed [FULL_W-1:0] lut [LUT_N];

        for (genvar a = 0; a < LUT_N; a++) begin : g_lut
            assign lut[a] = lut_val(a);
        end

        // One table lookup per bit plane, weighted by 2^b; the sign plane subtracts.
        always_comb begin
            logic signed [FULL_W-1:0] acc;
            logic signed [FULL_W-1:0] part;
            logic [N_TAPS-1:0]        addr;
            acc = '0;
            for (int b = 0; b < DATA_W; b++) begin
                for (int k = 0; k < N_TAPS; k++) begin
                    addr[k] = din[k*DATA_W + b];
                end
                part = lut[addr] <<< b;
                if (b == DATA_W - 1) acc = acc - part;
                else                 acc = acc + part;
            end
            sum = acc;
        end
    end else begin : g_mult
        always_comb begin
            logic signed [FULL_W-1:0] acc;
            logic signed [FULL_W-1:0] smp;
            logic signed [FULL_W-1:0] wgt;
            acc = '0;
            for (int k = 0; k < N_TAPS; k++) begin
                smp = FULL_W'($signed(din[k*DATA_W +: DATA_W]));
                wgt = FULL_W'(COEFS[k]);
                acc = acc + smp * wgt;
            end
            sum = acc;
        end
    end

endmodule

// File: rtl/sop_trunc.sv
// Output word forming: full width pass-through, or arithmetic shift and slice.
module sop_trunc #(
    parameter int FULL_W    = 22,
    parameter int RES_W     = 22,
    parameter bit FULL_RES  = 1'b1,
    parameter int TRUNC_LSB = 0
) (
    input  logic [FULL_W-1:0] sum,
    output logic [RES_W-1:0]  res
);

    if (FULL_RES) begin : g_full
        assign res = sum;
    end else begin : g_cut
        logic signed [FULL_W-1:0] shifted;
        assign shifted = $signed(sum) >>> TRUNC_LSB;
        for (genvar i = 0; i < RES_W; i++) begin : g_bit
            if (i < FULL_W) begin : g_in
                assign res[i] = shifted[i];
            end else begin : g_ext
                assign res[i] = shifted[FULL_W-1];
            end
        end
    end

endmodule

// File: rtl/sop_pipe.sv
// Delay line of STAGES registers with optional enable and asynchronous clear.
module sop_pipe #(
    parameter int W        = 22,
    parameter int STAGES   = 2,
    parameter bit USE_ENA  = 1'b1,
    parameter bit USE_ACLR = 1'b1
) (
    input  logic         clk,
    input  logic         aclr,
    input  logic         ena,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam int PS = (STAGES > 0) ? STAGES : 1;

    typedef struct packed {
        logic [PS-1:0][W-1:0] stg;
    } pipe_t;

    if (STAGES == 0) begin : g_wire
        assign q = d;
    end else begin : g_regs
        pipe_t pipe_d;
        pipe_t pipe_q;
        logic  adv;

        assign adv = USE_ENA ? ena : 1'b1;

        always_comb begin
            pipe_d = pipe_q;
            if (adv) begin
                pipe_d.stg[0] = d;
                for (int s = 1; s < STAGES; s++) begin
                    pipe_d.stg[s] = pipe_q.stg[s-1];
                end
            end
        end

        if (USE_ACLR) begin : g_clr
            always_ff @(posedge clk or posedge aclr) begin
                if (aclr) pipe_q <= '0;
                else      pipe_q <= pipe_d;
            end
        end else begin : g_noclr
            always_ff @(posedge clk) begin
                pipe_q <= pipe_d;
            end
        end

        assign q = pipe_q.stg[STAGES-1];
    end

endmodule

// File: rtl/coef_sop.sv
// Top: fixed-weight sum of products with selectable style, output forming and pipeline.
module coef_sop
    import sop_pkg::*;
#(
    parameter int        N_TAPS      = 8,
    parameter int        DATA_W      = 8,
    parameter int        COEF_W      = 11,
    parameter coef_tab_t COEFS       = '{-587, -844, -678, -100, 367, 362, 71, -244},
    parameter int        PIPE_STAGES = 2,
    parameter bit        FULL_RES    = 1'b1,
    parameter int        OUT_W       = 16,
    parameter int        TRUNC_LSB   = 0,
    parameter sop_impl_e IMPL        = IMPL_AUTO,
    parameter bit        USE_ENA     = 1'b1,
    parameter bit        USE_ACLR    = 1'b1,
    localparam int       FULL_W      = DATA_W + COEF_W + growth_bits(N_TAPS),
    localparam int       RES_W       = FULL_RES ? FULL_W : OUT_W
) (
    input  logic                     clk,
    input  logic                     aclr,
    input  logic                     ena,
    input  logic [N_TAPS*DATA_W-1:0] din,
    output logic [RES_W-1:0]         result
);

    localparam bit USE_TBL = pick_table(IMPL, N_TAPS, DATA_W);

    logic [FULL_W-1:0] sum_full;
    logic [RES_W-1:0]  res_tr;

    sop_core #(
        .N_TAPS (N_TAPS),
        .DATA_W (DATA_W),
        .COEFS  (COEFS),
        .FULL_W (FULL_W),
        .USE_TBL(USE_TBL)
    ) u_core (
        .din(din),
        .sum(sum_full)
    );

    sop_trunc #(
        .FULL_W   (FULL_W),
        .RES_W    (RES_W),
        .FULL_RES (FULL_RES),
        .TRUNC_LSB(TRUNC_LSB)
    ) u_trunc (
        .sum(sum_full),
        .res(res_tr)
    );

    sop_pipe #(
        .W       (RES_W),
        .STAGES  (PIPE_STAGES),
        .USE_ENA (USE_ENA),
        .USE_ACLR(USE_ACLR)
    ) u_pipe (
        .clk (clk),
        .aclr(aclr),
        .ena (ena),
        .d   (res_tr),
        .q   (result)
    );

endmodule

// File: rtl/coef_sop_chk.sv
// Property checker bound into every coef_sop instance.
module coef_sop_chk
    import sop_pkg::*;
#(
    parameter int        N_TAPS      = 8,
    parameter int        DATA_W      = 8,
    parameter coef_tab_t COEFS       = '{default: 0},
    parameter int        FULL_W      = 22,
    parameter int        RES_W       = 22,
    parameter bit        FULL_RES    = 1'b1,
    parameter int        TRUNC_LSB   = 0,
    parameter int        PIPE_STAGES = 2,
    parameter bit        USE_ENA     = 1'b1,
    parameter bit        USE_ACLR    = 1'b1
) (
    input logic                     clk,
    input logic                     aclr,
    input logic                     ena,
    input logic [N_TAPS*DATA_W-1:0] din,
    input logic [FULL_W-1:0]        sum_full,
    input logic [RES_W-1:0]         res_tr,
    input logic [RES_W-1:0]         result
);

    longint            ref_exact;
    logic [FULL_W-1:0] ref_full;
    logic [RES_W-1:0]  ref_res;
    logic              adv;

    always_comb begin
        longint acc;
        longint raw;
        longint span;
        span = longint'(1) << DATA_W;
        acc  = 0;
        for (int k = 0; k < N_TAPS; k++) begin
            raw = longint'(din >> (k*DATA_W)) & (span - 1);
            if (raw >= (span >>> 1)) raw = raw - span;
            acc = acc + raw * longint'(COEFS[k]);
        end
        ref_exact = acc;
    end

    assign ref_full = FULL_W'(ref_exact);
    assign ref_res  = FULL_RES ? RES_W'(ref_exact) : RES_W'(ref_exact >>> TRUNC_LSB);
    assign adv      = USE_ENA ? ena : 1'b1;

    AST_SUM_EXACT: assert property (@(posedge clk) disable iff (aclr) sum_full == ref_full); // R1
    AST_RES_SLICE: assert property (@(posedge clk) disable iff (aclr) res_tr == ref_res); // R4

    if (USE_ENA && PIPE_STAGES > 0) begin : g_hold
        AST_HOLD_ENA: assert property (@(posedge clk) disable iff (aclr) !ena |=> $stable(result)); // R7
    end

    if (USE_ACLR && PIPE_STAGES > 0) begin : g_clr
        always @(posedge clk) begin
            if (aclr) begin
                AST_CLEAR_ZERO: assert (result == '0); // R8
            end
        end
    end

    if (PIPE_STAGES == 1) begin : g_lat1
        AST_LAT_ONE: assert property (@(posedge clk) disable iff (aclr) adv |=> result == $past(res_tr)); // R5
    end

    if (PIPE_STAGES == 2) begin : g_lat2
        AST_LAT_TWO: assert property (@(posedge clk) disable iff (aclr) (adv && $past(adv) && !$past(aclr)) |=> result == $past(res_tr, 2)); // R5
    end

endmodule

bind coef_sop coef_sop_chk #(
    .N_TAPS     (N_TAPS),
    .DATA_W     (DATA_W),
    .COEFS      (COEFS),
    .FULL_W     (FULL_W),
    .RES_W      (RES_W),
    .FULL_RES   (FULL_RES),
    .TRUNC_LSB  (TRUNC_LSB),
    .PIPE_STAGES(PIPE_STAGES),
    .USE_ENA    (USE_ENA),
    .USE_ACLR   (USE_ACLR)
) u_chk (
    .clk     (clk),
    .aclr    (aclr),
    .ena     (ena),
    .din     (din),
    .sum_full(sum_full),
    .res_tr  (res_tr),
    .result  (result)
);

// File: tb/coef_sop_tb_top.sv
module coef_sop_tb_top;
    import sop_pkg::*;

    localparam int        CLK_PERIOD = 10;
    localparam coef_tab_t CM = '{-587, -844, -678, -100, 367, 362, 71, -244};
    localparam coef_tab_t CT = '{13, -16, 7, 100, -100, 55, -55, 1};
    localparam coef_tab_t CC = '{-8, 7, 0, 0, 0, 0, 0, 0};
    localparam int        NV = 10;
    localparam logic [63:0] VEC [NV] = '{
        64'h0000_0000_0000_0000,
        64'h0101_0101_0101_0101,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h8080_8080_8080_8080,
        64'h7F7F_7F7F_7F7F_7F7F,
        64'h807F_807F_807F_807F,
        64'h1234_5678_9ABC_DEF0,
        64'hA5A5_5A5A_0F0F_F0F0,
        64'h0000_0000_0000_0080,
        64'h7F00_0000_0000_0000
    };

    logic        clk = 1'b0;
    logic        aclr;
    logic        ena;
    logic [63:0] din_m;
    logic [17:0] din_t;
    logic [7:0]  din_c;
    logic [21:0] res_m;
    logic [21:0] res_d;
    logic [5:0]  res_t;
    logic [8:0]  res_c;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coef_sop #(.IMPL(IMPL_MULT)) dut_i (
        .clk(clk), .aclr(aclr), .ena(ena), .din(din_m), .result(res_m));

    coef_sop #(.IMPL(IMPL_DA)) dut_da_i (
        .clk(clk), .aclr(aclr), .ena(ena), .din(din_m), .result(res_d));

    coef_sop #(.N_TAPS(3), .DATA_W(6), .COEF_W(5), .COEFS(CT), .PIPE_STAGES(1),
               .FULL_RES(1'b0), .OUT_W(6), .TRUNC_LSB(3), .IMPL(IMPL_AUTO),
               .USE_ENA(1'b0), .USE_ACLR(1'b0)) dut_tr_i (
        .clk(clk), .aclr(aclr), .ena(ena), .din(din_t), .result(res_t));

    coef_sop #(.N_TAPS(2), .DATA_W(4), .COEF_W(4), .COEFS(CC), .PIPE_STAGES(0),
               .IMPL(IMPL_MULT)) dut_c_i (
        .clk(clk), .aclr(aclr), .ena(ena), .din(din_c), .result(res_c));

    function automatic longint model(input logic [63:0] v, input int n, input int d, input coef_tab_t c);
        longint acc;
        longint raw;
        longint span;
        span = longint'(1) << d;
        acc  = 0;
        for (int k = 0; k < n; k++) begin
            raw = longint'(v >> (k*d)) & (span - 1);
            if (raw >= (span >>> 1)) raw = raw - span;
            acc = acc + raw * longint'(c[k]);
        end
        return acc;
    endfunction

    function automatic longint m_of(input logic [63:0] v);
        return model(v, 8, 8, CM);
    endfunction

    function automatic longint t_of(input logic [63:0] v);
        return (model({46'd0, v[17:0]}, 3, 6, CT) >>> 3) & 63;
    endfunction

    function automatic longint c_of(input logic [63:0] v);
        return model({56'd0, v[7:0]}, 2, 4, CC);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] v);
        din_m = v;
        din_t = v[17:0];
        din_c = v[7:0];
    endtask

    task automatic edge_sample(input int n);
        for (int e = 0; e < n; e++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        aclr = 1'b1;
        ena  = 1'b1;
        apply(64'd0);

        // R8: reset state, and clear dominates new input
        edge_sample(3);
        chk("R8 reset state", longint'($signed(res_m)), 0);
        @(negedge clk);
        apply(VEC[2]);
        edge_sample(1);
        chk("R8 clear held over edge", longint'($signed(res_m)), 0);
        @(negedge clk);
        aclr = 1'b0;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            edge_sample(2);
            chk("R1 multiplier style", longint'($signed(res_m)), m_of(VEC[i]));
            chk("R3 table style matches", longint'($signed(res_d)), longint'($signed(res_m)));
            chk("R4 truncated output", longint'(res_t), t_of(VEC[i]));
            chk("R6 unregistered output", longint'($signed(res_c)), c_of(VEC[i]));
        end

        // R2: extreme codes, literal expected sums
        @(negedge clk);
        apply(VEC[3]);
        edge_sample(2);
        chk("R2 all most-negative", longint'($signed(res_m)), 211584);
        @(negedge clk);
        apply(VEC[4]);
        edge_sample(2);
        chk("R2 all most-positive", longint'($signed(res_d)), -209931);

        // R4 wrap and R10 unused weights: taps (-32, 31, -32) and (-32, -32, -32)
        @(negedge clk);
        apply(64'h207E0);
        edge_sample(1);
        chk("R4 upper bits dropped", longint'(res_t), 50);
        @(negedge clk);
        apply(64'h20820);
        edge_sample(1);
        chk("R10 extra weights ignored", longint'(res_t), 48);

        // R5: latency of two edges
        @(negedge clk);
        apply(VEC[5]);
        edge_sample(2);
        @(negedge clk);
        apply(VEC[6]);
        edge_sample(1);
        chk("R5 old sum before latency", longint'($signed(res_m)), m_of(VEC[5]));
        edge_sample(1);
        chk("R5 new sum after latency", longint'($signed(res_m)), m_of(VEC[6]));

        // R7: stall with different sums in flight; R9 on the enable-less instance
        @(negedge clk);
        apply(VEC[8]);
        edge_sample(1);
        @(negedge clk);
        ena = 1'b0;
        apply(VEC[9]);
        edge_sample(3);
        chk("R7 output frozen", longint'($signed(res_m)), m_of(VEC[6]));
        chk("R7 table output frozen", longint'($signed(res_d)), m_of(VEC[6]));
        chk("R9 enable ignored", longint'(res_t), t_of(VEC[9]));
        @(negedge clk);
        ena = 1'b1;
        edge_sample(1);
        chk("R7 in-flight sum first", longint'($signed(res_m)), m_of(VEC[8]));
        edge_sample(1);
        chk("R7 stalled input second", longint'($signed(res_m)), m_of(VEC[9]));

        // R8: clear mid-cycle takes effect before any edge
        @(negedge clk);
        #2;
        aclr = 1'b1;
        #1;
        chk("R8 immediate clear", longint'($signed(res_m)), 0);
        chk("R8 immediate clear table", longint'($signed(res_d)), 0);
        @(negedge clk);
        aclr = 1'b0;
        edge_sample(2);
        chk("R5 refill after clear", longint'($signed(res_m)), m_of(VEC[9]));

        // R6: output follows input with no edge
        @(negedge clk);
        apply(VEC[6]);
        #1;
        chk("R6 no edge needed", longint'($signed(res_c)), c_of(VEC[6]));
        apply(VEC[7]);
        #1;
        chk("R6 second change", longint'($signed(res_c)), c_of(VEC[7]));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule